// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that produces a steady stream of periods for an operating-system tick or a free-running time base. A fixed divide-by-16 prescaler on the system clock steps a 20-bit interval count. The count climbs from zero to a software-programmed limit and then returns to zero. Each return to zero marks one elapsed period. It sets a sticky period flag and adds one to a 12-bit period tally. The tally saturates instead of wrapping.

Software programs the limit as the wanted period minus one, then turns on counting and, if it wants, the interrupt. The interrupt is a level signal. It is high while the period flag is set and the interrupt is enabled. Two read-only views return the same snapshot of tally and interval count. The acknowledging view clears the flag and the tally as a side effect. The peek view has no side effect, so a time-base reader can sample the count without disturbing the interrupt path.

When counting is switched off, the current period still runs to its end. The interval count then rests at zero, so software can wait for zero to know the timer has stopped.

Top module: `ivt_timer`

## Requirements
- R1: After reset all four registers read zero and `irq_o` is low.
- R2: While counting is on, the interval count rises by exactly one every 16 clock cycles.
- R3: The control register at byte offset 0x0 holds the limit in bits 19:0, counting-on in bit 24 and interrupt-on in bit 25, and it reads back as written in those bits. The interval count goes 0, 1, …, limit and then 0 again, so one period lasts (limit+1)·16 cycles.
- R4: The status register at offset 0x4 shows the period flag in bit 0. The flag is set by every return of the interval count to zero.
- R5: A read of offset 0x8 returns the period tally in bits 31:20 and the interval count in bits 19:0. The tally is the number of periods since the previous such read. The read clears both the tally and the flag.
- R6: A read of offset 0xC returns the same fields as offset 0x8 and changes neither the flag nor the tally.
- R7: The period tally stops at 4095 and does not wrap.
- R8: When a period ends in the same cycle as an acknowledging read, the flag stays set and the tally becomes 1.
- R9: After counting is switched off, a nonzero interval count keeps rising until it returns to zero, and that return counts as a period. The count then holds at zero.
- R10: `irq_o` is high exactly while the flag is set and interrupt-on is 1. Counting proceeds with interrupt-on cleared.
- R11: Writes to offsets 0x4, 0x8 and 0xC change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded from `bus_addr` in the same cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that a read strobe on the acknowledging offset lasts one clock cycle per intended acknowledge. They also assume the limit is not lowered below the running count by a write in mid-period. The stimulus holds `bus_sel` for one edge per read or write. It changes the limit only after a reset, so the interval count never starts above its limit. The bench expects the count, the tally and the flag from elapsed clock edges and the acknowledge history alone. It times one acknowledge to land exactly on a period end, so the colliding case is driven on purpose.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CNT_W   = 20;
    localparam int PER_W   = DATA_W - CNT_W;
    localparam int RUN_BIT = 24;
    localparam int IRQ_BIT = 25;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_VALUE = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_PEEK  = 4'hC;

    typedef struct packed {
        logic             irq_on;
        logic             run_on;
        logic [CNT_W-1:0] limit;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.irq_on = w[IRQ_BIT];
        c.run_on = w[RUN_BIT];
        c.limit  = w[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[IRQ_BIT]     = c.irq_on;
        w[RUN_BIT]     = c.run_on;
        w[CNT_W-1:0]   = c.limit;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] snap_word(input logic [PER_W-1:0] per,
                                                    input logic [CNT_W-1:0] cnt);
        return {per, cnt};
    endfunction

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            pre_q <= '0;
        end else if (pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = active && (pre_q == LAST);
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    // at or above the limit ends the period, so a lowered limit cannot strand the count
    assign wrap = tick && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ivt_plog.sv
module ivt_plog #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         ack,
    output logic         flag,
    output logic [W-1:0] periods
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            periods <= '0;
        end else if (wrap) begin
            flag    <= 1'b1;
            if (ack) begin
                periods <= W'(1);
            end else if (periods != TOP) begin
                periods <= periods + 1'b1;
            end
        end else if (ack) begin
            flag    <= 1'b0;
            periods <= '0;
        end
    end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    ctrl_t            ctrl_q;
    logic             ctrl_we;
    logic             ack;
    logic             active;
    logic             tick;
    logic             wrap;
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] periods;

    assign ctrl_we = bus_sel && bus_wr && (bus_addr == OFF_CTRL);
    assign ack     = bus_sel && !bus_wr && (bus_addr == OFF_VALUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_from_word(bus_wdata);
        end
    end

    // keep running after switch-off until the period is finished
    assign active = ctrl_q.run_on || (cnt != '0);

    ivt_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .tick   (tick)
    );

    ivt_count #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .limit (ctrl_q.limit),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    ivt_plog #(.W(PER_W)) u_log (
        .clk     (clk),
        .rst     (rst),
        .wrap    (wrap),
        .ack     (ack),
        .flag    (flag),
        .periods (periods)
    );

    always_comb begin
        unique case (bus_addr)
            OFF_CTRL:  bus_rdata = ctrl_to_word(ctrl_q);
            OFF_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, flag};
            OFF_VALUE: bus_rdata = snap_word(periods, cnt);
            OFF_PEEK:  bus_rdata = snap_word(periods, cnt);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = flag && ctrl_q.irq_on;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             wrap,
    input logic             ack,
    input logic             run_on,
    input logic             flag,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt,
    input logic [PER_W-1:0] periods
);
    localparam logic [PER_W-1:0] TOP = {PER_W{1'b1}};

    assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> $past(tick));

    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (ack && !wrap) |=> (!flag && periods == '0));

    assert_tally_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        (periods == TOP && !ack) |=> (periods == TOP));

    assert_wrap_beats_ack_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && wrap) |=> (flag && periods == PER_W'(1)));

    assert_rest_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!run_on && cnt == '0) |=> (cnt == '0));

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag);
endmodule

bind ivt_timer ivt_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wrap    (wrap),
    .ack     (ack),
    .run_on  (ctrl_q.run_on),
    .flag    (flag),
    .irq_o   (irq_o),
    .cnt     (cnt),
    .periods (periods)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    always #4 clk = ~clk;   // 125 MHz

    ivt_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int t_edges = 0;
    bit track = 1'b0;
    int lim_m = 0;
    int p_last = 0;

    always @(posedge clk) if (track) t_edges <= t_edges + 1;

    function automatic int m_cnt();
        return (t_edges / 16) % (lim_m + 1);
    endfunction
    function automatic int m_per();
        return (t_edges / 16) / (lim_m + 1);
    endfunction
    function automatic int m_pend();
        int d;
        d = m_per() - p_last;
        return (d > 4095) ? 4095 : d;
    endfunction
    function automatic logic [31:0] m_snap();
        return (32'(m_pend()) << 20) | 32'(m_cnt());
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; track = 1'b0; t_edges = 0; p_last = 0;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic image_check(input string req);
        logic [31:0] d;
        peek(4'hC, d);
        check(req, d, m_snap());
    endtask

    task automatic status_check(input string req);
        logic [31:0] d;
        peek(4'h4, d);
        check(req, d, (m_pend() > 0) ? 32'h1 : 32'h0);
    endtask

    task automatic value_read(input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'h8;
        #1;
        check(req, bus_rdata, m_snap());
        p_last = m_per();
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic start(input logic [31:0] ctrl, input int lim);
        bus_write(4'h0, ctrl);
        lim_m = lim; p_last = 0; t_edges = 0; track = 1'b1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int exp_p;

        // R1: reset state
        do_reset();
        peek(4'h0, d); check("R1 ctrl", d, 32'h0);
        peek(4'h4, d); check("R1 stat", d, 32'h0);
        peek(4'h8, d); check("R1 value", d, 32'h0);
        peek(4'hC, d); check("R1 peek", d, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        // R3: limit 3, counting on, interrupt off
        start(32'h0100_0003, 3);
        peek(4'h0, d); check("R3 ctrl readback", d, 32'h0100_0003);

        // R2 R3 R6 R4 R10: sweep of sample points with interrupt off
        for (int i = 0; i < 40; i++) begin
            idle(i % 7 + 3);
            image_check("R2 R3 R6 snapshot");
            status_check("R4 flag");
            check("R10 irq masked", {31'h0, irq_o}, 32'h0);
        end

        // R10: turn interrupt on without disturbing the count
        bus_write(4'h0, 32'h0300_0003);
        check("R10 irq raised", {31'h0, irq_o}, (m_pend() > 0) ? 32'h1 : 32'h0);

        // R5: acknowledging read, then state cleared
        idle(1);
        value_read("R5 value");
        image_check("R5 after ack");
        status_check("R5 flag after ack");
        check("R10 irq after ack", {31'h0, irq_o}, (m_pend() > 0) ? 32'h1 : 32'h0);

        // R8: line the acknowledge up with a period end
        idle(20);
        while (!(((t_edges + 1) % 16 == 0) && (((t_edges + 1) / 16) % (lim_m + 1) == 0)))
            idle(1);
        value_read("R8 value at wrap");
        peek(4'h4, d); check("R8 flag kept", d, 32'h1);
        peek(4'hC, d); check("R8 tally one", {20'h0, d[31:20]}, 32'h1);
        check("R8 irq kept", {31'h0, irq_o}, 32'h1);

        // R11: writes elsewhere change nothing
        bus_write(4'h4, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'hC, 32'hFFFF_FFFF);
        peek(4'h0, d); check("R11 ctrl unchanged", d, 32'h0300_0003);
        image_check("R11 snapshot unchanged");

        // R9: switch off mid-period, the period completes, then rests
        do_reset();
        start(32'h0100_0005, 5);
        idle(16 * 2 + 5);
        bus_write(4'h0, 32'h0000_0005);
        track = 1'b0;
        exp_p = m_per() + ((m_cnt() != 0) ? 1 : 0);
        idle(16 * 8);
        peek(4'hC, d); check("R9 drained", d, 32'(exp_p) << 20);
        idle(100);
        peek(4'hC, d); check("R9 holds zero", d, 32'(exp_p) << 20);
        peek(4'h4, d); check("R9 flag", d, (exp_p > 0) ? 32'h1 : 32'h0);

        // R7: tally saturation with limit 0
        do_reset();
        start(32'h0100_0000, 0);
        idle(4096 * 16 + 40);
        image_check("R7 saturated snapshot");
        peek(4'hC, d); check("R7 tally top", {20'h0, d[31:20]}, 32'd4095);
        value_read("R7 value");
        image_check("R7 after ack");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule